// File: doc/BRIEF.md
# Overlapping Byte/Word Register File

This block holds the eight 16-bit working registers of a small processor datapath. There are four general registers (accumulator, count, data, base) and four pointer registers (stack pointer, base pointer, source index, destination index). Every register can be read and written as a full word. The four general registers can also be reached as two independent byte halves. Because the byte and word views share the same storage, a byte write merges into its 16-bit register and leaves the other half untouched.

The block has two combinational read ports and one write port. Each port takes a 3-bit index and a byte/word flag. The flag selects which index map applies. Byte reads come back zero-extended to 16 bits. Writes commit on the rising clock edge, so a read of a register in the same cycle it is written returns the value it held before that edge. A synchronous active-high reset clears the whole file to zero.

Top module: `ovrf_regfile`

## Requirements
- R1: With the byte flag low, index 0..7 selects AX, CX, DX, BX, SP, BP, SI, DI in that order. A word write stores all 16 bits of `wr_data`, and a later word read of the same index returns that value.
- R2: With the byte flag high, index 0..3 selects the low byte of AX, CX, DX, BX and index 4..7 selects the high byte of those same registers. A byte read returns the selected byte in bits 7:0, with bits 15:8 zero.
- R3: A byte write stores `wr_data[7:0]` into the selected half only. The other half of that register keeps its value, and `wr_data[15:8]` has no effect.
- R4: SP, BP, SI and DI can only be changed by word writes. No byte index reaches them, so byte writes leave them unchanged.
- R5: Reads are combinational. A write becomes visible on the read ports only after the rising edge that commits it, so a same-cycle read returns the old value.
- R6: The two read ports are independent and return identical data when given the same index and flag. A byte read and a word read of the same register agree on the shared byte.
- R7: While `wr_en` is low, no register changes, whatever the other write inputs carry.
- R8: A rising edge with `rst` high clears every register to zero, and it overrides a write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write register index |
| wr_byte | input | 1 | Write uses the byte map (1) or the word map (0) |
| wr_data | input | 16 | Write data; only bits 7:0 are used on a byte write |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_byte | input | 1 | Read port 0 byte/word flag |
| rd0_data | output | 16 | Read port 0 data, zero-extended on a byte read |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_byte | input | 1 | Read port 1 byte/word flag |
| rd1_data | output | 16 | Read port 1 data, zero-extended on a byte read |

## Verification
The bound checker covers the properties that hold on every cycle:
- zero-extension of byte reads and agreement between the two read ports;
- a word write reading back on the next cycle;
- a byte write merging with the other half, whenever port 1 happened to show the old word the cycle before;
- a register holding its value while writes are off;
- all zeros after reset.

Other behaviour depends on a particular sequence of accesses, so only the directed scenarios can show it. This includes the old-value result of a same-cycle read, the exact byte index map and the isolation of the pointer registers from byte writes. It also includes `wr_data[15:8]` being ignored and reset winning over a concurrent write.

// File: rtl/ovrf_pkg.sv
package ovrf_pkg;

  localparam int DEF_WORD_W      = 16;
  localparam int DEF_NUM_REGS    = 8;
  localparam int DEF_NUM_BYTE_RG = 4;

  // Write enables for the two byte lanes of one register.
  typedef struct packed {
    logic hi;
    logic lo;
  } lane_we_t;

endpackage

// File: rtl/ovrf_wr_decode.sv
module ovrf_wr_decode
  import ovrf_pkg::*;
#(
  parameter int NUM_REGS    = DEF_NUM_REGS,
  parameter int NUM_BYTE_RG = DEF_NUM_BYTE_RG,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BSEL_W = $clog2(NUM_BYTE_RG)
) (
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_byte,
  output lane_we_t [NUM_REGS-1:0]       lane_we
);

  logic [BSEL_W-1:0] byte_reg;
  logic              byte_hi;

  // Byte map: low bits pick the register, the next bit picks the half.
  assign byte_reg = wr_idx[BSEL_W-1:0];
  assign byte_hi  = wr_idx[BSEL_W];

  always_comb begin
    lane_we = '0;
    if (wr_en) begin
      if (wr_byte) begin
        if (byte_hi) lane_we[byte_reg].hi = 1'b1;
        else         lane_we[byte_reg].lo = 1'b1;
      end else begin
        lane_we[wr_idx].hi = 1'b1;
        lane_we[wr_idx].lo = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ovrf_lane_bank.sv
module ovrf_lane_bank
  import ovrf_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int WORD_W   = DEF_WORD_W,
  localparam int BYTE_W  = WORD_W / 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  lane_we_t [NUM_REGS-1:0]          lane_we,
  input  logic [BYTE_W-1:0]                lo_din,
  input  logic [BYTE_W-1:0]                hi_din,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_q
);

  // Each register is two separately enabled byte lanes.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lane_we[r].lo) lo_q <= lo_din;
        if (lane_we[r].hi) hi_q <= hi_din;
      end
    end

    assign regs_q[r] = {hi_q, lo_q};
  end

endmodule

// File: rtl/ovrf_rd_port.sv
module ovrf_rd_port
  import ovrf_pkg::*;
#(
  parameter int NUM_REGS    = DEF_NUM_REGS,
  parameter int NUM_BYTE_RG = DEF_NUM_BYTE_RG,
  parameter int WORD_W      = DEF_WORD_W,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BSEL_W = $clog2(NUM_BYTE_RG),
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q,
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic                            rd_byte,
  output logic [WORD_W-1:0]               rd_data
);

  logic [WORD_W-1:0] byte_word;
  logic [BYTE_W-1:0] byte_val;

  assign byte_word = regs_q[rd_idx[BSEL_W-1:0]];
  assign byte_val  = rd_idx[BSEL_W] ? byte_word[WORD_W-1:BYTE_W]
                                    : byte_word[BYTE_W-1:0];

  always_comb begin
    if (rd_byte) rd_data = {{(WORD_W-BYTE_W){1'b0}}, byte_val};
    else         rd_data = regs_q[rd_idx];
  end

endmodule

// File: rtl/ovrf_regfile.sv
module ovrf_regfile
  import ovrf_pkg::*;
#(
  parameter int NUM_REGS    = DEF_NUM_REGS,
  parameter int NUM_BYTE_RG = DEF_NUM_BYTE_RG,
  parameter int WORD_W      = DEF_WORD_W,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_byte,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic              rd0_byte,
  output logic [WORD_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic              rd1_byte,
  output logic [WORD_W-1:0] rd1_data
);

  lane_we_t [NUM_REGS-1:0]         lane_we;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
  logic [BYTE_W-1:0]               lo_din;
  logic [BYTE_W-1:0]               hi_din;

  // A byte write always sources the low byte of the write bus.
  assign lo_din = wr_data[BYTE_W-1:0];
  assign hi_din = wr_byte ? wr_data[BYTE_W-1:0] : wr_data[WORD_W-1:BYTE_W];

  ovrf_wr_decode #(
    .NUM_REGS   (NUM_REGS),
    .NUM_BYTE_RG(NUM_BYTE_RG)
  ) u_wr_decode (
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_byte(wr_byte),
    .lane_we(lane_we)
  );

  ovrf_lane_bank #(
    .NUM_REGS(NUM_REGS),
    .WORD_W  (WORD_W)
  ) u_lane_bank (
    .clk    (clk),
    .rst    (rst),
    .lane_we(lane_we),
    .lo_din (lo_din),
    .hi_din (hi_din),
    .regs_q (regs_q)
  );

  ovrf_rd_port #(
    .NUM_REGS   (NUM_REGS),
    .NUM_BYTE_RG(NUM_BYTE_RG),
    .WORD_W     (WORD_W)
  ) u_rd0 (
    .regs_q (regs_q),
    .rd_idx (rd0_idx),
    .rd_byte(rd0_byte),
    .rd_data(rd0_data)
  );

  ovrf_rd_port #(
    .NUM_REGS   (NUM_REGS),
    .NUM_BYTE_RG(NUM_BYTE_RG),
    .WORD_W     (WORD_W)
  ) u_rd1 (
    .regs_q (regs_q),
    .rd_idx (rd1_idx),
    .rd_byte(rd1_byte),
    .rd_data(rd1_data)
  );

endmodule

// File: rtl/ovrf_regfile_chk.sv
module ovrf_regfile_chk #(
  parameter int NUM_REGS    = 8,
  parameter int NUM_BYTE_RG = 4,
  parameter int WORD_W      = 16,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BSEL_W = $clog2(NUM_BYTE_RG),
  localparam int BYTE_W = WORD_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              wr_byte,
  input logic [WORD_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic              rd0_byte,
  input logic [WORD_W-1:0] rd0_data,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic              rd1_byte,
  input logic [WORD_W-1:0] rd1_data
);

  // One-cycle history of the ports, used by the read-back checks.
  logic              q_rst, q_wr_en, q_wr_byte, q_rd0_byte, q_rd1_byte;
  logic [IDX_W-1:0]  q_wr_idx, q_rd0_idx, q_rd1_idx;
  logic [WORD_W-1:0] q_wr_data, q_rd0_data, q_rd1_data;
  logic              past_rst_q = 1'b0;

  always_ff @(posedge clk) begin
    q_rst      <= rst;
    q_wr_en    <= wr_en;
    q_wr_byte  <= wr_byte;
    q_wr_idx   <= wr_idx;
    q_wr_data  <= wr_data;
    q_rd0_idx  <= rd0_idx;
    q_rd0_byte <= rd0_byte;
    q_rd0_data <= rd0_data;
    q_rd1_idx  <= rd1_idx;
    q_rd1_byte <= rd1_byte;
    q_rd1_data <= rd1_data;
  end

  logic [IDX_W-1:0]  merge_tgt;
  logic              merge_ok;
  logic [WORD_W-1:0] merge_exp;

  assign merge_tgt = IDX_W'(q_wr_idx[BSEL_W-1:0]);
  assign merge_ok  = q_wr_en && q_wr_byte && !q_rst && !q_rd1_byte && (q_rd1_idx == merge_tgt);
  assign merge_exp = q_wr_idx[BSEL_W]
                   ? {q_wr_data[BYTE_W-1:0], q_rd1_data[BYTE_W-1:0]}
                   : {q_rd1_data[WORD_W-1:BYTE_W], q_wr_data[BYTE_W-1:0]};

  assert_word_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (q_wr_en && !q_wr_byte && !q_rst && !rd0_byte && rd0_idx == q_wr_idx)
      |-> rd0_data == q_wr_data);

  assert_byte_zero_ext0_R2: assert property (@(posedge clk) disable iff (rst)
    rd0_byte |-> rd0_data[WORD_W-1:BYTE_W] == '0);

  assert_byte_zero_ext1_R2: assert property (@(posedge clk) disable iff (rst)
    rd1_byte |-> rd1_data[WORD_W-1:BYTE_W] == '0);

  assert_byte_merge_R3: assert property (@(posedge clk) disable iff (rst)
    (merge_ok && !rd0_byte && rd0_idx == merge_tgt) |-> rd0_data == merge_exp);

  assert_ports_agree_R6: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == rd1_idx && rd0_byte == rd1_byte) |-> rd0_data == rd1_data);

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!q_wr_en && !q_rst && !q_rd0_byte && !rd0_byte && rd0_idx == q_rd0_idx)
      |-> rd0_data == q_rd0_data);

  // R8: in the cycle after a reset edge, both ports read zero.
  always_ff @(posedge clk) begin
    past_rst_q <= rst;
    if (past_rst_q == 1'b1)
      assert_reset_clears_R8: assert (rd0_data == '0 && rd1_data == '0);
  end

endmodule

bind ovrf_regfile ovrf_regfile_chk #(
  .NUM_REGS   (NUM_REGS),
  .NUM_BYTE_RG(NUM_BYTE_RG),
  .WORD_W     (WORD_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_byte (wr_byte),
  .wr_data (wr_data),
  .rd0_idx (rd0_idx),
  .rd0_byte(rd0_byte),
  .rd0_data(rd0_data),
  .rd1_idx (rd1_idx),
  .rd1_byte(rd1_byte),
  .rd1_data(rd1_data)
);

// File: tb/ovrf_regfile_bench.sv
module ovrf_regfile_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic        wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd0_idx = '0;
  logic        rd0_byte = 1'b0;
  logic [15:0] rd0_data;
  logic [2:0]  rd1_idx = '0;
  logic        rd1_byte = 1'b0;
  logic [15:0] rd1_data;

  int vectors = 0;
  int fails   = 0;
  logic [15:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ovrf_regfile u_ovrf_regfile (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_byte(rd1_byte), .rd1_data(rd1_data)
  );

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Byte map per R2: index bit 2 picks the high half of word index[1:0].
  function automatic logic [15:0] exp_read(input logic [2:0] idx, input logic byt);
    logic [15:0] w;
    if (!byt) return model[idx];
    w = model[{1'b0, idx[1:0]}];
    return idx[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic read_both(input logic [2:0] idx, input logic byt, input string tag);
    rd0_idx = idx; rd0_byte = byt;
    rd1_idx = idx; rd1_byte = byt;
    #1;
    check16({tag, " port0"}, rd0_data, exp_read(idx, byt));
    check16({tag, " port1 R6"}, rd1_data, exp_read(idx, byt));
  endtask

  task automatic do_write(input logic [2:0] idx, input logic byt, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_byte = byt; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (!byt) model[idx] = d;
    else if (idx[2]) model[{1'b0, idx[1:0]}][15:8] = d[7:0];
    else model[{1'b0, idx[1:0]}][7:0] = d[7:0];
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 3'd0; wr_byte = 1'b0; wr_data = 16'hFFFF;
    @(posedge clk); #1;
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) read_both(3'(i), 1'b0, "R8 reset clears word");
  endtask

  task automatic t_word_all();
    for (int i = 0; i < 8; i++) do_write(3'(i), 1'b0, 16'(i * 16'h1357 + 16'h2468));
    for (int i = 0; i < 8; i++) read_both(3'(i), 1'b0, "R1 word readback");
  endtask

  task automatic t_byte_read();
    for (int i = 0; i < 8; i++) read_both(3'(i), 1'b1, "R2 byte read map");
    rd0_idx = 3'd6; rd0_byte = 1'b1; rd1_idx = 3'd2; rd1_byte = 1'b0; #1;
    check16("R6 byte view matches word high half", rd0_data, {8'h00, rd1_data[15:8]});
  endtask

  task automatic t_byte_write();
    do_write(3'd2, 1'b1, 16'hA5C3);
    read_both(3'd2, 1'b0, "R3 low byte merge, upper data ignored");
    do_write(3'd7, 1'b1, 16'h9977);
    read_both(3'd3, 1'b0, "R3 high byte merge");
    for (int i = 0; i < 8; i++) do_write(3'(i), 1'b1, 16'h00E1 + 16'(i));
    for (int i = 4; i < 8; i++) read_both(3'(i), 1'b0, "R4 pointer regs untouched by bytes");
    for (int i = 0; i < 4; i++) read_both(3'(i), 1'b0, "R3 both halves byte-written");
    do_write(3'd6, 1'b0, 16'hBEEF);
    read_both(3'd6, 1'b0, "R4 pointer word write");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_byte = 1'b0; wr_data = 16'h5A5A;
    rd0_idx = 3'd5; rd0_byte = 1'b0; rd1_idx = 3'd5; rd1_byte = 1'b0;
    #1;
    check16("R5 same-cycle read returns old", rd0_data, model[5]);
    @(posedge clk); #1;
    wr_en = 1'b0;
    model[5] = 16'h5A5A;
    check16("R5 new value after edge", rd0_data, 16'h5A5A);
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd1; wr_byte = 1'b0; wr_data = 16'hDEAD;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) read_both(3'(i), 1'b0, "R7 no change while disabled");
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 3'd4; wr_byte = 1'b0; wr_data = 16'h1234;
    @(posedge clk); #1;
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) read_both(3'(i), 1'b0, "R8 reset overrides write");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_word_all();
    t_byte_read();
    t_byte_write();
    t_same_cycle();
    t_idle();
    t_byte_read();
    t_reset_mid();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule